// File: doc/BRIEF.md
# Serial DAC Host Write Controller

This block sits on a fast system clock and turns channel/code write commands into pin-level traffic for a four-channel serial converter. A command arrives on a valid/ready handshake with a 2-bit channel, a 12-bit code and a load flag. The controller then runs chip select, the serial clock and serial data for one 16-bit frame. When the load flag is set, it follows the frame with an active-low load strobe. Several writes with the flag clear, followed by one write with the flag set, update all channels together.

A separate reset request takes a reset-select level. The controller applies that level first and then pulses the converter's active-low reset. Every minimum pin interval is a parameter in picoseconds. Each one is turned into a whole number of system clock cycles by rounding up. An optional settling wait after a load or reset is held in the same way before the controller takes the next request.

Top module: `dacwr_ctrl`

## Requirements
- R1: Each command produces one frame of 16 serial-clock rising edges while chip select is low. The bits sampled at those edges are, in order: channel bit 1, channel bit 0, two zero bits, then the 12-bit code from bit 11 down to bit 0.
- R2: After reset, and whenever the controller is idle: chip select is high, the serial clock is low, the load strobe is high, the converter reset is high and cmd_ready_o is 1.
- R3: Serial data changes only while the serial clock is low. Data is stable for at least T_DS before each rising edge and is held for at least T_DH after it.
- R4: Every serial clock high phase lasts at least T_CH and every low phase at least T_CL.
- R5: Chip select falls at least T_CSS before the first rising edge and rises at least T_CSH after the last rising edge. The serial clock never rises while chip select is high.
- R6: A frame whose load flag is 1 is followed by exactly one load pulse before the next frame. That pulse falls after chip select has risen and at least T_LD2 after the last rising edge, and it stays low at least T_LDW. A frame whose load flag is 0 produces no load pulse.
- R7: The load strobe has been high for at least T_LD1 before any serial clock rising edge.
- R8: cmd_ready_o is 0 from the cycle after a command is accepted until the frame and any load pulse are done. After a load pulse it returns to 1 no sooner than the settling time after the strobe rises.
- R9: An accepted reset request drives the reset-select pin to rst_sel_i at least T_RSS before the converter reset falls. The reset then stays low at least T_RSTW. Reset-select keeps that level afterwards.
- R10: When a reset request and a command are both presented while the controller is idle, the reset sequence runs first and the command is accepted only after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Controller idle, command can be taken |
| cmd_chan_i | input | 2 | Channel address |
| cmd_code_i | input | 12 | Converter code |
| cmd_load_i | input | 1 | Pulse the load strobe after this frame |
| rst_req_i | input | 1 | Request a converter reset sequence |
| rst_sel_i | input | 1 | Reset-select level to apply |
| dac_cs_n_o | output | 1 | Chip select, active low |
| dac_sclk_o | output | 1 | Serial clock |
| dac_sdi_o | output | 1 | Serial data |
| dac_ld_n_o | output | 1 | Load strobe, active low |
| dac_rst_n_o | output | 1 | Converter reset, active low |
| dac_rstsel_o | output | 1 | Reset-select level |

## Verification
Every pin output is a register that changes on a clock edge. A command accepted at one edge therefore shows chip select low at the next sample. A pin event is then seen exactly one cycle after the edge at which the controller's phase counter expires. The monitor samples on the falling system clock. It timestamps each pin edge in cycles and compares the gap between related edges with the rounded-up minimum computed in the bench. The frame word is compared with the scoreboard entry at the chip-select rising edge. The load-pulse count for a frame is settled at the next chip-select falling edge, or after the final drain.

// File: rtl/dacwr_pkg.sv
// Package: shared state type and cycle conversion helpers for the serial
// DAC write controller. Assumes all times are given in picoseconds.
package dacwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RSEL,
        ST_RLOW,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_LOAD,
        ST_WAIT
    } state_e;

    // Round a time up to whole clock cycles, never less than one.
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacwr_timer.sv
// Phase timer: loads a terminal count and counts down to zero.
// Assumes the owner loads (duration - 1), so a phase lasts exactly
// 'duration' cycles from the edge that loads it.
module dacwr_timer #(
    parameter int TW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          done_o
);

    logic [TW-1:0] cnt_q;

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/dacwr_frame.sv
// Frame shifter: holds the outgoing word and presents its MSB as serial
// data. Assumes shift_i is raised only on the clock falling-edge step and
// only while bits remain.
module dacwr_frame #(
    parameter int FRAME_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               shift_i,
    output logic               msb_o,
    output logic               last_o
);

    localparam int CW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sh_q;
    logic [CW-1:0]      left_q;

    // Capture a new word or move to the next bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sh_q   <= word_i;
            left_q <= CW'(FRAME_W - 1);
        end else if (shift_i) begin
            sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign msb_o  = sh_q[FRAME_W-1];
    assign last_o = (left_q == '0);

    // R1: never asked to move past the final bit of a frame.
    p_no_extra_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |-> (left_q != '0));

endmodule

// File: rtl/dacwr_ctrl.sv
// Serial DAC write controller: takes channel/code commands and reset
// requests on a handshake and sequences chip select, serial clock, data,
// load strobe, reset and reset-select with parameterised minimum intervals.
// Assumes one system clock; all pin outputs are registered.
module dacwr_ctrl
    import dacwr_pkg::*;
#(
    parameter int CLK_PS     = 4000,
    parameter int CHAN_W     = 2,
    parameter int CODE_W     = 12,
    parameter int PAD_W      = 2,
    parameter int T_DS_PS    = 25000,
    parameter int T_DH_PS    = 20000,
    parameter int T_CH_PS    = 30000,
    parameter int T_CL_PS    = 50000,
    parameter int T_CSS_PS   = 55000,
    parameter int T_CSH_PS   = 15000,
    parameter int T_LD1_PS   = 40000,
    parameter int T_LD2_PS   = 15000,
    parameter int T_LDW_PS   = 45000,
    parameter int T_RSS_PS   = 25000,
    parameter int T_RSTW_PS  = 70000,
    parameter int SETTLE_PS  = 10000000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [CHAN_W-1:0] cmd_chan_i,
    input  logic [CODE_W-1:0] cmd_code_i,
    input  logic              cmd_load_i,
    input  logic              rst_req_i,
    input  logic              rst_sel_i,
    output logic              dac_cs_n_o,
    output logic              dac_sclk_o,
    output logic              dac_sdi_o,
    output logic              dac_ld_n_o,
    output logic              dac_rst_n_o,
    output logic              dac_rstsel_o
);

    localparam int FRAME_W  = CHAN_W + PAD_W + CODE_W;
    localparam int LOW_C    = imax(ps_to_cyc(T_CL_PS, CLK_PS), ps_to_cyc(T_DS_PS, CLK_PS));
    localparam int HIGH_C   = imax(ps_to_cyc(T_CH_PS, CLK_PS), ps_to_cyc(T_DH_PS, CLK_PS));
    localparam int FIRST_C  = imax(ps_to_cyc(T_CSS_PS, CLK_PS), LOW_C);
    localparam int LAST_C   = imax(HIGH_C, imax(ps_to_cyc(T_CSH_PS, CLK_PS),
                                                ps_to_cyc(T_LD2_PS, CLK_PS)));
    localparam int LDW_C    = ps_to_cyc(T_LDW_PS, CLK_PS);
    localparam int SETTLE_C = ps_to_cyc(SETTLE_PS, CLK_PS);
    localparam int LDWAIT_C = imax(ps_to_cyc(T_LD1_PS, CLK_PS), SETTLE_C);
    localparam int RSS_C    = ps_to_cyc(T_RSS_PS, CLK_PS);
    localparam int RSTW_C   = ps_to_cyc(T_RSTW_PS, CLK_PS);
    localparam int MAX_C    = imax(imax(imax(LOW_C, HIGH_C), imax(FIRST_C, LAST_C)),
                                   imax(imax(LDW_C, LDWAIT_C), imax(RSS_C, RSTW_C)));
    localparam int TW       = $clog2(MAX_C + 1);

    localparam logic [TW-1:0] LOW_T    = TW'(LOW_C - 1);
    localparam logic [TW-1:0] HIGH_T   = TW'(HIGH_C - 1);
    localparam logic [TW-1:0] FIRST_T  = TW'(FIRST_C - 1);
    localparam logic [TW-1:0] LAST_T   = TW'(LAST_C - 1);
    localparam logic [TW-1:0] LDW_T    = TW'(LDW_C - 1);
    localparam logic [TW-1:0] LDWAIT_T = TW'(LDWAIT_C - 1);
    localparam logic [TW-1:0] SETTLE_T = TW'(SETTLE_C - 1);
    localparam logic [TW-1:0] RSS_T    = TW'(RSS_C - 1);
    localparam logic [TW-1:0] RSTW_T   = TW'(RSTW_C - 1);

    state_e             state_q;
    logic               cs_n_q, sclk_q, ld_n_q, rst_n_q, rsel_q, ldflag_q;
    logic               tm_load, tm_done;
    logic [TW-1:0]      tm_val;
    logic               fr_load, fr_shift, fr_last, fr_msb;
    logic [FRAME_W-1:0] fr_word;
    logic               take_rst, take_cmd;

    assign take_rst = (state_q == ST_IDLE) && rst_req_i;
    assign take_cmd = (state_q == ST_IDLE) && !rst_req_i && cmd_valid_i;
    assign fr_word  = {cmd_chan_i, {PAD_W{1'b0}}, cmd_code_i};
    assign fr_load  = take_cmd;
    assign fr_shift = (state_q == ST_HIGH) && tm_done && !fr_last;

    dacwr_timer #(.TW(TW)) timer_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tm_load),
        .val_i  (tm_val),
        .done_o (tm_done)
    );

    dacwr_frame #(.FRAME_W(FRAME_W)) frame_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (fr_load),
        .word_i (fr_word),
        .shift_i(fr_shift),
        .msb_o  (fr_msb),
        .last_o (fr_last)
    );

    // Pick the length of the phase being entered at this edge.
    always_comb begin
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (take_rst) begin
                    tm_load = 1'b1;
                    tm_val  = RSS_T;
                end else if (take_cmd) begin
                    tm_load = 1'b1;
                    tm_val  = FIRST_T;
                end
            end
            ST_RSEL: begin
                tm_load = tm_done;
                tm_val  = RSTW_T;
            end
            ST_RLOW: begin
                tm_load = tm_done;
                tm_val  = SETTLE_T;
            end
            ST_LOW: begin
                tm_load = tm_done;
                tm_val  = fr_last ? LAST_T : HIGH_T;
            end
            ST_HIGH: begin
                tm_load = tm_done && !fr_last;
                tm_val  = LOW_T;
            end
            ST_GAP: begin
                tm_load = 1'b1;
                tm_val  = LDW_T;
            end
            ST_LOAD: begin
                tm_load = tm_done;
                tm_val  = LDWAIT_T;
            end
            default: begin
                tm_load = 1'b0;
                tm_val  = '0;
            end
        endcase
    end

    // Sequence state and registered pin levels.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            cs_n_q   <= 1'b1;
            sclk_q   <= 1'b0;
            ld_n_q   <= 1'b1;
            rst_n_q  <= 1'b1;
            rsel_q   <= 1'b0;
            ldflag_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take_rst) begin
                        rsel_q  <= rst_sel_i;
                        state_q <= ST_RSEL;
                    end else if (take_cmd) begin
                        cs_n_q   <= 1'b0;
                        ldflag_q <= cmd_load_i;
                        state_q  <= ST_LOW;
                    end
                end
                ST_RSEL: if (tm_done) begin
                    rst_n_q <= 1'b0;
                    state_q <= ST_RLOW;
                end
                ST_RLOW: if (tm_done) begin
                    rst_n_q <= 1'b1;
                    state_q <= ST_WAIT;
                end
                ST_LOW: if (tm_done) begin
                    sclk_q  <= 1'b1;
                    state_q <= ST_HIGH;
                end
                ST_HIGH: if (tm_done) begin
                    sclk_q <= 1'b0;
                    if (fr_last) begin
                        cs_n_q  <= 1'b1;
                        state_q <= ldflag_q ? ST_GAP : ST_IDLE;
                    end else begin
                        state_q <= ST_LOW;
                    end
                end
                ST_GAP: begin
                    ld_n_q  <= 1'b0;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: if (tm_done) begin
                    ld_n_q  <= 1'b1;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: if (tm_done) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready_o  = (state_q == ST_IDLE);
    assign dac_cs_n_o   = cs_n_q;
    assign dac_sclk_o   = sclk_q;
    assign dac_sdi_o    = fr_msb;
    assign dac_ld_n_o   = ld_n_q;
    assign dac_rst_n_o  = rst_n_q;
    assign dac_rstsel_o = rsel_q;

    // R5: the serial clock is low whenever chip select is high.
    p_sclk_low_deselected_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_cs_n_o |-> !dac_sclk_o);

    // R2: an idle controller shows the idle pin levels.
    p_idle_levels_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_ready_o |-> (dac_cs_n_o && !dac_sclk_o && dac_ld_n_o && dac_rst_n_o));

    // R6: the load strobe is never low during a frame.
    p_load_outside_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dac_ld_n_o |-> dac_cs_n_o);

    // R3: serial data does not move while the serial clock stays high.
    p_data_held_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dac_sclk_o && $past(dac_sclk_o)) |-> $stable(dac_sdi_o));

    // R9: reset-select is frozen while the converter reset is low.
    p_rstsel_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dac_rst_n_o |-> $stable(dac_rstsel_o));

endmodule

// File: tb/dacwr_ctrl_tb.sv
`timescale 1ns/1ps
module dacwr_ctrl_tb_top;

    // Minimum intervals in cycles of a 4 ns clock, rounded up.
    function automatic int cyc(input int ns);
        return (ns + 3) / 4;
    endfunction
    localparam int DS = cyc(25), DH = cyc(20), CH = cyc(30), CL = cyc(50);
    localparam int CSS = cyc(55), CSH = cyc(15), LD1 = cyc(40), LD2 = cyc(15);
    localparam int LDW = cyc(45), RSS = cyc(25), RSTW = cyc(70), SETTLE = cyc(10000);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready, cmd_load = 1'b0;
    logic [1:0] cmd_chan = '0;
    logic [11:0] cmd_code = '0;
    logic rst_req = 1'b0, rst_sel = 1'b0;
    logic cs_n, sclk, sdi, ld_n, drst_n, rsel;

    always #2 clk = ~clk;

    dacwr_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_chan_i(cmd_chan), .cmd_code_i(cmd_code), .cmd_load_i(cmd_load),
        .rst_req_i(rst_req), .rst_sel_i(rst_sel), .dac_cs_n_o(cs_n), .dac_sclk_o(sclk),
        .dac_sdi_o(sdi), .dac_ld_n_o(ld_n), .dac_rst_n_o(drst_n), .dac_rstsel_o(rsel)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [16:0] exp_q[$];
    logic rst_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: timestamps pin edges and scores them.
    int  now = 0, t_sdi = -100000, t_rise = -100000, t_fall = -100000, t_csf = 0;
    int  t_ldr = -100000, t_ldf = 0, t_rsel = 0, t_rstf = 0, nbits = 0, ld_cnt = 0;
    bit  p_cs = 1, p_sclk = 0, p_sdi = 0, p_ld = 1, p_rst = 1, p_rsel = 0, p_rdy = 1;
    bit  have_pend = 0, pend_ld = 0, after_ld = 0;
    logic [15:0] got = '0;

    task automatic settle_load_count();
        if (have_pend) chk(ld_cnt == int'(pend_ld), "R6 load pulses per frame", ld_cnt, pend_ld);
        have_pend = 0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            p_cs = cs_n; p_sclk = sclk; p_sdi = sdi; p_ld = ld_n;
            p_rst = drst_n; p_rsel = rsel; p_rdy = cmd_ready;
        end else begin
            now++;
            if (sdi != p_sdi) begin
                chk(!sclk, "R3 data moves with clock low", sclk, 0);
                chk(now - t_rise >= DH, "R3 hold", now - t_rise, DH);
                t_sdi = now;
            end
            if (!cs_n && p_cs) begin
                settle_load_count();
                chk(!cmd_ready, "R8 ready low in frame", cmd_ready, 0);
                t_csf = now; nbits = 0; after_ld = 0;
            end
            if (sclk && !p_sclk) begin
                chk(!cs_n, "R5 rise only when selected", cs_n, 0);
                chk(now - t_sdi >= DS, "R3 setup", now - t_sdi, DS);
                chk(now - t_fall >= CL, "R4 low time", now - t_fall, CL);
                chk(now - t_ldr >= LD1, "R7 load high before rise", now - t_ldr, LD1);
                if (nbits == 0) chk(now - t_csf >= CSS, "R5 select setup", now - t_csf, CSS);
                got = {got[14:0], sdi}; nbits++; t_rise = now;
            end
            if (!sclk && p_sclk) begin
                chk(now - t_rise >= CH, "R4 high time", now - t_rise, CH);
                t_fall = now;
            end
            if (cs_n && !p_cs) begin
                chk(now - t_rise >= CSH, "R5 select hold", now - t_rise, CSH);
                chk(!cmd_ready || ld_n == 1'b1, "R8 ready at frame end", cmd_ready, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R1 unexpected frame", got, 0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    chk(nbits == 16, "R1 bit count", nbits, 16);
                    chk(got == e[15:0], "R1 frame word", got, e[15:0]);
                    pend_ld = e[16]; have_pend = 1; ld_cnt = 0;
                end
            end
            if (!ld_n && p_ld) begin
                chk(cs_n, "R6 load after select rises", cs_n, 1);
                chk(now - t_rise >= LD2, "R6 load after last rise", now - t_rise, LD2);
                chk(!cmd_ready, "R8 ready low in load", cmd_ready, 0);
                ld_cnt++; t_ldf = now;
            end
            if (ld_n && !p_ld) begin
                chk(now - t_ldf >= LDW, "R6 load width", now - t_ldf, LDW);
                t_ldr = now; after_ld = 1;
            end
            if (cmd_ready && !p_rdy && after_ld) begin
                chk(now - t_ldr >= SETTLE, "R8 settle after load", now - t_ldr, SETTLE);
                after_ld = 0;
            end
            if (rsel != p_rsel) begin
                chk(drst_n, "R9 select moves with reset high", drst_n, 1);
                t_rsel = now;
            end
            if (!drst_n && p_rst) begin
                chk(now - t_rsel >= RSS, "R9 select setup", now - t_rsel, RSS);
                if (rst_q.size() == 0) chk(0, "R9 unexpected reset", 1, 0);
                else begin
                    logic s;
                    s = rst_q.pop_front();
                    chk(rsel == s, "R9 select level", rsel, s);
                end
                t_rstf = now;
            end
            if (drst_n && !p_rst)
                chk(now - t_rstf >= RSTW, "R9 reset width", now - t_rstf, RSTW);
            p_cs = cs_n; p_sclk = sclk; p_sdi = sdi; p_ld = ld_n;
            p_rst = drst_n; p_rsel = rsel; p_rdy = cmd_ready;
        end
    end

    // Driver: hold a command until the controller takes it, then score it.
    task automatic send(input logic [1:0] ch, input logic [11:0] code, input logic ld);
        @(negedge clk);
        cmd_valid = 1; cmd_chan = ch; cmd_code = code; cmd_load = ld;
        while (!(cmd_ready && !rst_req)) @(negedge clk);
        exp_q.push_back({ld, ch, 2'b00, code});
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst_req = 1; rst_sel = sel;
        while (!cmd_ready) @(negedge clk);
        rst_q.push_back(sel);
        @(negedge clk);
        rst_req = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || rst_q.size() != 0 || !cmd_ready) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(cs_n == 1 && sclk == 0 && ld_n == 1 && drst_n == 1 && cmd_ready == 1,
            "R2 idle after reset", {cs_n, sclk, ld_n, drst_n, cmd_ready}, 5'b10111);
        rst_n = 1;
        do_reset(1'b1);
        do_reset(1'b0);
        // Staged writes, one shared update at the end (R6)
        send(2'd0, 12'hFFF, 0);
        send(2'd1, 12'h000, 0);
        send(2'd2, 12'hA5A, 0);
        send(2'd3, 12'h5A5, 1);
        send(2'd2, 12'h801, 1);
        send(2'd1, 12'h001, 0);
        drain();
        // R10: reset wins over a simultaneous command
        @(negedge clk);
        rst_req = 1; rst_sel = 1; cmd_valid = 1; cmd_chan = 2'd3; cmd_code = 12'h3C7; cmd_load = 1;
        rst_q.push_back(1'b1);
        @(negedge clk);
        rst_req = 0;
        chk(rsel == 1 && cs_n == 1 && !cmd_ready, "R10 reset taken first",
            {rsel, cs_n, cmd_ready}, 3'b110);
        while (!cmd_ready) @(negedge clk);
        exp_q.push_back({1'b1, 2'd3, 2'b00, 12'h3C7});
        @(negedge clk);
        cmd_valid = 0;
        drain();
        settle_load_count();
        chk(cs_n == 1 && sclk == 0 && ld_n == 1 && drst_n == 1 && cmd_ready == 1,
            "R2 idle at end", {cs_n, sclk, ld_n, drst_n, cmd_ready}, 5'b10111);
        chk(rsel == 1, "R9 select kept", rsel, 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule